// File: doc/BRIEF.md
# Camera Alarm Controller with Timed Self-Clearing Hold

This block watches four camera channels for trouble. Each channel has an external alarm contact and a field-sync pulse from its video decoder. A contact closure that passes a stability filter, or a channel whose sync pulses stop, starts an alarm on that channel. The alarm then stays up for a programmed number of one-second ticks and clears itself. A new trigger during that time starts the count again.

While a channel is alarming, the block gives the overlay logic a per-channel status flag, which serves as the text enable, and a flash flag that blinks at a fixed half-period. Any active alarm drives an alarm output to external equipment. The same condition drives a buzzer, which a configuration bit can mute. Every trigger is recorded in a small log as a cause, a channel and a seconds timestamp. The log can be read back one entry at a time. When the log is full, the oldest entry is dropped.

Top module: `cam_alarm_ctrl`

## Requirements
- R1: Each alarm input passes through two synchronizer flops and is accepted only after 4 consecutive equal synchronized samples. A level change held for at least 4 clocks sets `alm_act` at the 8th rising edge after the change: edge 0 is the first edge that samples it. Edges 0 through 6 do not yet show it. A pulse of 3 clocks or fewer has no effect.
- R2: When no `vsync` pulse arrives for LOSS_CYC = FIELD_CYC*LOSS_FIELDS clocks after the edge that sampled the last pulse, `vid_lost` rises at edge LOSS_CYC after that edge, and `alm_act` follows one edge later. `vid_lost` clears at the first edge that samples a new sync pulse.
- R3: After reset, `alm_act`, `flash`, `buzzer` and `alarm_out` are all 0, `log_empty` is 1 and `log_count` is 0.
- R4: An alarm stays active for H second ticks, where H is `cfg_hold` sampled at the trigger and forced into the range 1..300: 0 gives 1, and values above 300 give 300. The channel clears on the edge that takes tick number H.
- R5: A new trigger on a channel that is already active reloads its hold count to the full value.
- R6: `flash` is 1 on the activation edge and inverts every HALF_CYC clocks while the channel is active. It is 0 whenever the channel is inactive.
- R7: `alarm_out` is 1 while any channel is active. `buzzer` equals `alarm_out` AND `cfg_buzz_en`.
- R8: Each trigger writes one log entry holding a cause (0 = external input, 1 = video loss), a channel number and the seconds count. The seconds count is the number of `sec_tick` pulses seen since reset. Triggers pending in the same cycle are logged one per clock: ascending channel first, then external before video loss within a channel. The head entry appears on `log_cause`, `log_chan` and `log_time`.
- R9: The log keeps the DEPTH (8) most recent entries. A write to a full log with no read discards the oldest entry.
- R10: A `log_rd` pulse while the log is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_in | input | NCH | External alarm contacts, asynchronous, active high |
| vsync | input | NCH | Per-channel field-sync pulse, one clock wide, synchronous |
| sec_tick | input | 1 | One-clock pulse each second |
| cfg_hold | input | 9 | Alarm hold time in seconds |
| cfg_buzz_en | input | 1 | Buzzer enable |
| alm_act | output | NCH | Per-channel alarm status, also the text enable |
| flash | output | NCH | Per-channel blink flag for the picture |
| vid_lost | output | NCH | Per-channel video loss indication |
| buzzer | output | 1 | Buzzer drive |
| alarm_out | output | 1 | Alarm output to external equipment |
| log_rd | input | 1 | Pop the head log entry |
| log_empty | output | 1 | Log holds no entries |
| log_count | output | $clog2(DEPTH)+1 | Number of stored entries |
| log_cause | output | 1 | Head entry cause: 0 external, 1 video loss |
| log_chan | output | $clog2(NCH) | Head entry channel |
| log_time | output | TS_W | Head entry seconds count |

## Verification
An external input change reaches `alm_act` on the 8th edge: two synchronizer stages, four history samples and the registered accept stage come first. The bench counts edges from the drive and samples on the falling edge after the 7th edge, where it expects 0, and after the 8th, where it expects 1. Video loss is timed from the edge that took the last sync pulse, with `vid_lost` checked at edges LOSS_CYC-1 and LOSS_CYC and `alm_act` one edge later. The hold count and the flash phase are checked on the edge that takes each tick and at each of the first 20 clocks after activation. Log contents are read only after the triggers have settled, and no tick is issued between a trigger and its log write, so every timestamp equals the bench's own tick count.

// File: rtl/cam_alarm_pkg.sv
// Shared definitions for the camera alarm controller.
// Assumes: the hold time is carried on HOLD_W bits and limited to HOLD_MAX.
package cam_alarm_pkg;

    localparam int HOLD_W   = 9;
    localparam int HOLD_MAX = 300;

    typedef enum logic {
        CAUSE_EXT   = 1'b0,
        CAUSE_VLOSS = 1'b1
    } cause_e;

    // Force a configured hold time into the legal range 1..HOLD_MAX.
    function automatic logic [HOLD_W-1:0] hold_clamp(input logic [HOLD_W-1:0] v);
        if (v == '0)
            return HOLD_W'(1);
        else if (v > HOLD_W'(HOLD_MAX))
            return HOLD_W'(HOLD_MAX);
        else
            return v;
    endfunction

endpackage

// File: rtl/cam_alarm_debounce.sv
// Alarm input conditioner: two-flop synchronizer followed by a stability
// filter. The accepted level changes only after STABLE_N equal samples.
// rise_o pulses for one clock when the level is accepted high.
// Assumes: din is asynchronous to clk; STABLE_N >= 2.
module cam_alarm_debounce #(
    parameter int STABLE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o
);

    logic [1:0]          sync_q;
    logic [STABLE_N-1:0] hist_q;
    logic                level_q;
    logic                rise_q;

    // Synchronize the input and shift it into the sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[STABLE_N-2:0], sync_q[1]};
        end
    end

    // Accept a new level once the whole history agrees; flag the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else if ((&hist_q) && !level_q) begin
            level_q <= 1'b1;
            rise_q  <= 1'b1;
        end else if (!(|hist_q) && level_q) begin
            level_q <= 1'b0;
            rise_q  <= 1'b0;
        end else begin
            rise_q  <= 1'b0;
        end
    end

    assign level_o = level_q;
    assign rise_o  = rise_q;

    // R1
    accept_needs_full_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (level_q && $past(&hist_q)));

endmodule

// File: rtl/cam_alarm_vidloss.sv
// Video presence monitor for one channel. It counts clocks since the last
// field-sync pulse and declares loss after LOSS_CYC clocks without one.
// Assumes: sync_i is a synchronous pulse; LOSS_CYC >= 2.
module cam_alarm_vidloss #(
    parameter int LOSS_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic lost_o,
    output logic rise_o
);

    localparam int               LW   = $clog2(LOSS_CYC);
    localparam logic [LW-1:0]    LAST = LW'(LOSS_CYC - 1);

    logic [LW-1:0] cnt_q;
    logic          lost_q;
    logic          rise_q;

    // Restart on every sync pulse, otherwise count up to the loss limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
            rise_q <= 1'b0;
        end else if (sync_i) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (cnt_q == LAST && !lost_q) begin
                lost_q <= 1'b1;
                rise_q <= 1'b1;
            end
            if (cnt_q != LAST)
                cnt_q <= cnt_q + LW'(1);
        end
    end

    assign lost_o = lost_q;
    assign rise_o = rise_q;

    // R2
    loss_without_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> !$past(sync_i));

    // R2
    sync_clears_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> !lost_q);

endmodule

// File: rtl/cam_alarm_chan.sv
// Per-channel alarm state: hold countdown in seconds and blink phase.
// A trigger (re)loads the hold count; each second tick decrements it and
// the channel clears on the tick that would take the count to zero.
// Assumes: hold_i is already within 1..HOLD_MAX; HALF_CYC >= 2.
module cam_alarm_chan
    import cam_alarm_pkg::*;
#(
    parameter int HALF_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              sec_tick_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              active_o,
    output logic              flash_o
);

    localparam int            FW     = $clog2(HALF_CYC);
    localparam logic [FW-1:0] F_LAST = FW'(HALF_CYC - 1);

    logic              active_q;
    logic              flash_q;
    logic [HOLD_W-1:0] rem_q;
    logic [FW-1:0]     fcnt_q;

    // Load on trigger, count seconds down and blink while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            flash_q  <= 1'b0;
            rem_q    <= '0;
            fcnt_q   <= '0;
        end else if (trig_i) begin
            active_q <= 1'b1;
            flash_q  <= 1'b1;
            rem_q    <= hold_i;
            fcnt_q   <= '0;
        end else if (active_q) begin
            if (sec_tick_i && rem_q == HOLD_W'(1)) begin
                active_q <= 1'b0;
                flash_q  <= 1'b0;
                fcnt_q   <= '0;
            end else begin
                if (sec_tick_i)
                    rem_q <= rem_q - HOLD_W'(1);
                if (fcnt_q == F_LAST) begin
                    fcnt_q  <= '0;
                    flash_q <= ~flash_q;
                end else begin
                    fcnt_q <= fcnt_q + FW'(1);
                end
            end
        end
    end

    assign active_o = active_q;
    assign flash_o  = flash_q;

    // R6
    flash_only_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_q |-> active_q);

    // R4
    clear_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> $past(sec_tick_i));

    // R4
    hold_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (rem_q != '0 && rem_q <= HOLD_W'(HOLD_MAX)));

    // R5
    trigger_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (active_q && rem_q == $past(hold_i)));

endmodule

// File: rtl/cam_alarm_log.sv
// Event log: collects per-source triggers as pending bits, writes one per
// clock by fixed priority into a circular buffer of DEPTH entries, and
// drops the oldest entry when a write meets a full buffer.
// Source index = channel*2 + cause, so lower channels win and external
// inputs win over video loss within a channel.
// Assumes: DEPTH and NCH are powers of two.
module cam_alarm_log
    import cam_alarm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 8,
    parameter int TS_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           trig_ext_i,
    input  logic [NCH-1:0]           trig_loss_i,
    input  logic                     sec_tick_i,
    input  logic                     rd_i,
    output logic                     empty_o,
    output logic [$clog2(DEPTH):0]   count_o,
    output logic                     cause_o,
    output logic [$clog2(NCH)-1:0]   chan_o,
    output logic [TS_W-1:0]          time_o
);

    localparam int SRC  = 2 * NCH;
    localparam int IW   = $clog2(SRC);
    localparam int CW   = $clog2(NCH);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = AW + 1;

    typedef struct packed {
        cause_e          cause;
        logic [CW-1:0]   chan;
        logic [TS_W-1:0] ts;
    } ent_t;

    logic [SRC-1:0]  trig_vec;
    logic [SRC-1:0]  pend_q;
    logic [IW-1:0]   gnt_idx;
    logic            wr;
    logic            full;
    logic            do_rd;
    logic            ovw;
    logic [AW-1:0]   wptr_q;
    logic [AW-1:0]   rptr_q;
    logic [CNTW-1:0] count_q;
    logic [TS_W-1:0] ts_q;
    ent_t            mem_q [DEPTH];
    ent_t            head;

    // Interleave the trigger sources into priority order.
    for (genvar c = 0; c < NCH; c++) begin : g_src
        assign trig_vec[2*c]   = trig_ext_i[c];
        assign trig_vec[2*c+1] = trig_loss_i[c];
    end

    // Pick the lowest-numbered pending source.
    always_comb begin
        gnt_idx = '0;
        wr      = 1'b0;
        for (int i = 0; i < SRC; i++) begin
            if (pend_q[i] && !wr) begin
                gnt_idx = IW'(i);
                wr      = 1'b1;
            end
        end
    end

    assign full  = (count_q == CNTW'(DEPTH));
    assign do_rd = rd_i && (count_q != '0);
    assign ovw   = wr && full && !do_rd;

    // Track pending sources, pointers, fill level and the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            ts_q    <= '0;
        end else begin
            pend_q <= (pend_q & ~(wr ? (SRC'(1) << gnt_idx) : '0)) | trig_vec;
            if (wr)
                wptr_q <= wptr_q + AW'(1);
            if (do_rd || ovw)
                rptr_q <= rptr_q + AW'(1);
            count_q <= count_q + CNTW'(wr) - CNTW'(do_rd) - CNTW'(ovw);
            if (sec_tick_i)
                ts_q <= ts_q + TS_W'(1);
        end
    end

    // Store the granted event at the write pointer.
    always_ff @(posedge clk) begin
        if (wr)
            mem_q[wptr_q] <= '{cause: cause_e'(gnt_idx[0]), chan: gnt_idx[IW-1:1], ts: ts_q};
    end

    assign head    = mem_q[rptr_q];
    assign empty_o = (count_q == '0);
    assign count_o = count_q;
    assign cause_o = head.cause;
    assign chan_o  = head.chan;
    assign time_o  = head.ts;

    // R9
    fill_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNTW'(DEPTH));

    // R9
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovw |=> (count_q == CNTW'(DEPTH)));

    // R10
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && count_q == '0 && pend_q == '0) |=> (count_q == '0));

    // R8
    trigger_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_vec) |=> (pend_q != '0 || count_q != $past(count_q) || $past(ovw)));

endmodule

// File: rtl/cam_alarm_ctrl.sv
// Camera alarm controller top. Per channel: input conditioner, video
// presence monitor and alarm state; shared: event log, buzzer and output.
// Assumes: sec_tick and vsync are synchronous one-clock pulses.
module cam_alarm_ctrl
    import cam_alarm_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int STABLE_N    = 4,
    parameter int FIELD_CYC   = 1_000_000,
    parameter int LOSS_FIELDS = 3,
    parameter int HALF_CYC    = 25_000_000,
    parameter int DEPTH       = 8,
    parameter int TS_W        = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           alarm_in,
    input  logic [NCH-1:0]           vsync,
    input  logic                     sec_tick,
    input  logic [8:0]               cfg_hold,
    input  logic                     cfg_buzz_en,
    output logic [NCH-1:0]           alm_act,
    output logic [NCH-1:0]           flash,
    output logic [NCH-1:0]           vid_lost,
    output logic                     buzzer,
    output logic                     alarm_out,
    input  logic                     log_rd,
    output logic                     log_empty,
    output logic [$clog2(DEPTH):0]   log_count,
    output logic                     log_cause,
    output logic [$clog2(NCH)-1:0]   log_chan,
    output logic [TS_W-1:0]          log_time
);

    localparam int LOSS_CYC = FIELD_CYC * LOSS_FIELDS;

    logic [NCH-1:0]    ext_level;
    logic [NCH-1:0]    ext_rise;
    logic [NCH-1:0]    loss_rise;
    logic [HOLD_W-1:0] hold_eff;

    assign hold_eff = hold_clamp(cfg_hold);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cam_alarm_debounce #(.STABLE_N(STABLE_N)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (alarm_in[c]),
            .level_o (ext_level[c]),
            .rise_o  (ext_rise[c])
        );

        cam_alarm_vidloss #(.LOSS_CYC(LOSS_CYC)) u_vl (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (vsync[c]),
            .lost_o (vid_lost[c]),
            .rise_o (loss_rise[c])
        );

        cam_alarm_chan #(.HALF_CYC(HALF_CYC)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (ext_rise[c] | loss_rise[c]),
            .sec_tick_i (sec_tick),
            .hold_i     (hold_eff),
            .active_o   (alm_act[c]),
            .flash_o    (flash[c])
        );
    end

    cam_alarm_log #(.NCH(NCH), .DEPTH(DEPTH), .TS_W(TS_W)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_ext_i  (ext_rise),
        .trig_loss_i (loss_rise),
        .sec_tick_i  (sec_tick),
        .rd_i        (log_rd),
        .empty_o     (log_empty),
        .count_o     (log_count),
        .cause_o     (log_cause),
        .chan_o      (log_chan),
        .time_o      (log_time)
    );

    assign alarm_out = |alm_act;
    assign buzzer    = alarm_out & cfg_buzz_en;

    // R7
    buzzer_implies_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |-> alarm_out);

    // R7
    enabled_buzzer_sounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_buzz_en && alarm_out) |-> buzzer);

    // R1
    level_before_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_level) |=> (alm_act == ($past(alm_act) | $past(ext_rise) | $past(loss_rise)) || $past(sec_tick)));

endmodule

// File: tb/tb_cam_alarm_ctrl.sv
// Bench for cam_alarm_ctrl with a small timing configuration.
module tb_cam_alarm_ctrl;

    localparam int NCH = 4, FIELD_CYC = 10, LOSS_FIELDS = 3, HALF_CYC = 5;
    localparam int DEPTH = 8, TS_W = 16;
    localparam int LOSS_CYC = FIELD_CYC * LOSS_FIELDS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  alarm_in = '0;
    logic [NCH-1:0]  vsync = '0;
    logic [NCH-1:0]  voff = '0;
    logic            sec_tick = 1'b0;
    logic [8:0]      cfg_hold = 9'd3;
    logic            cfg_buzz_en = 1'b1;
    logic [NCH-1:0]  alm_act, flash, vid_lost;
    logic            buzzer, alarm_out, log_rd = 1'b0, log_empty, log_cause;
    logic [3:0]      log_count;
    logic [1:0]      log_chan;
    logic [TS_W-1:0] log_time;

    int n_tests = 0, n_fail = 0, nticks = 0, t0 = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cam_alarm_ctrl #(.NCH(NCH), .STABLE_N(4), .FIELD_CYC(FIELD_CYC), .LOSS_FIELDS(LOSS_FIELDS),
                     .HALF_CYC(HALF_CYC), .DEPTH(DEPTH), .TS_W(TS_W)) dut (
        .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .vsync(vsync), .sec_tick(sec_tick),
        .cfg_hold(cfg_hold), .cfg_buzz_en(cfg_buzz_en), .alm_act(alm_act), .flash(flash),
        .vid_lost(vid_lost), .buzzer(buzzer), .alarm_out(alarm_out), .log_rd(log_rd),
        .log_empty(log_empty), .log_count(log_count), .log_cause(log_cause),
        .log_chan(log_chan), .log_time(log_time));

    // Field-sync pulses every FIELD_CYC clocks on channels not switched off.
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) vsync[c] = (phase == 0) && !voff[c];
            phase = (phase == FIELD_CYC - 1) ? 0 : phase + 1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1; nticks++;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); log_rd = 1'b1;
        @(negedge clk); log_rd = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R3 reset state
        chk("R3 alm_act", alm_act, 0);
        chk("R3 flash", flash, 0);
        chk("R3 alarm_out", alarm_out, 0);
        chk("R3 buzzer", buzzer, 0);
        chk("R3 log_empty", log_empty, 1);
        chk("R3 log_count", log_count, 0);

        // R1 a 3-clock glitch is ignored
        @(negedge clk); alarm_in[0] = 1'b1;
        wait_n(3); alarm_in[0] = 1'b0;
        wait_n(15);
        chk("R1 glitch act", alm_act, 0);
        chk("R1 glitch log", log_count, 0);

        // R1 latency of an accepted input: edges 0..6 quiet, edge 7 active
        @(negedge clk); alarm_in[1] = 1'b1;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R1 before accept", alm_act[1], 0);
        @(posedge clk); @(negedge clk);
        chk("R1 accepted", alm_act[1], 1);
        chk("R7 alarm_out", alarm_out, 1);
        chk("R7 buzzer", buzzer, 1);
        // R6 blink sweep over 20 clocks from activation
        chk("R6 flash k=0", flash[1], 1);
        for (int k = 1; k < 20; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R6 flash sweep", flash[1], ((k / HALF_CYC) % 2 == 0) ? 1 : 0);
        end

        // R4 hold of 3 ticks
        tick(); chk("R4 after tick1", alm_act[1], 1);
        tick(); chk("R4 after tick2", alm_act[1], 1);
        tick(); chk("R4 after tick3", alm_act[1], 0);
        chk("R6 flash off", flash[1], 0);
        chk("R7 out off", alarm_out, 0);
        alarm_in[1] = 1'b0; wait_n(10);

        // R5 retrigger reloads the hold count
        alarm_in[1] = 1'b1; wait_n(10);
        tick(); tick();
        alarm_in[1] = 1'b0; wait_n(10);
        alarm_in[1] = 1'b1; wait_n(10);
        tick(); chk("R5 reload t1", alm_act[1], 1);
        tick(); chk("R5 reload t2", alm_act[1], 1);
        tick(); chk("R5 reload t3", alm_act[1], 0);
        alarm_in[1] = 1'b0;

        // R7 buzzer mute
        cfg_buzz_en = 1'b0;
        alarm_in[3] = 1'b1; wait_n(10);
        chk("R7 muted buzzer", buzzer, 0);
        chk("R7 muted out", alarm_out, 1);
        cfg_buzz_en = 1'b1; wait_n(1);
        chk("R7 unmuted buzzer", buzzer, 1);
        tick(); tick(); tick();
        chk("R4 ch3 cleared", alm_act[3], 0);
        alarm_in[3] = 1'b0;

        // R4 clamping: 0 acts as 1, 301 acts as 300
        cfg_hold = 9'd0;
        alarm_in[2] = 1'b1; wait_n(10);
        chk("R4 zero hold active", alm_act[2], 1);
        tick(); chk("R4 zero hold clears", alm_act[2], 0);
        alarm_in[2] = 1'b0; wait_n(10);
        cfg_hold = 9'd301;
        alarm_in[2] = 1'b1; wait_n(10);
        for (int i = 0; i < 299; i++) tick();
        chk("R4 clamp 299", alm_act[2], 1);
        tick(); chk("R4 clamp 300", alm_act[2], 0);
        alarm_in = '0; wait_n(20);

        // drain, then R10 empty read
        for (int i = 0; i < 2 * DEPTH; i++) if (!log_empty) pop();
        chk("R9 drained", log_empty, 1);
        pop();
        chk("R10 count", log_count, 0);
        chk("R10 empty", log_empty, 1);

        // R2 video loss on channel 2
        cfg_hold = 9'd1;
        do @(posedge clk); while (vsync[2] !== 1'b1);
        @(negedge clk); voff[2] = 1'b1;
        repeat (LOSS_CYC - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet lost", vid_lost[2], 0);
        @(posedge clk); @(negedge clk);
        chk("R2 lost", vid_lost[2], 1);
        chk("R2 act not yet", alm_act[2], 0);
        @(posedge clk); @(negedge clk);
        chk("R2 act", alm_act[2], 1);
        wait_n(5);
        chk("R8 loss count", log_count, 1);
        chk("R8 loss cause", log_cause, 1);
        chk("R8 loss chan", log_chan, 2);
        chk("R8 loss time", log_time, nticks);
        voff[2] = 1'b0;
        do @(posedge clk); while (vsync[2] !== 1'b1);
        @(negedge clk);
        chk("R2 restored", vid_lost[2], 0);
        tick(); chk("R4 loss hold", alm_act[2], 0);
        pop();

        // R8 simultaneous triggers: channel 0 logged before channel 3
        @(negedge clk); alarm_in[0] = 1'b1; alarm_in[3] = 1'b1;
        wait_n(15);
        chk("R8 pair count", log_count, 2);
        chk("R8 first chan", log_chan, 0);
        chk("R8 first cause", log_cause, 0);
        chk("R8 first time", log_time, nticks);
        pop();
        chk("R8 second chan", log_chan, 3);
        pop();
        chk("R8 pair drained", log_empty, 1);
        alarm_in = '0; wait_n(10);

        // R9 ten events into an eight-entry log keep the newest eight
        t0 = nticks;
        for (int i = 0; i < 10; i++) begin
            alarm_in[0] = 1'b1; wait_n(10);
            alarm_in[0] = 1'b0; wait_n(10);
            tick();
        end
        chk("R9 full count", log_count, DEPTH);
        for (int j = 0; j < DEPTH; j++) begin
            chk("R9 entry time", log_time, t0 + 2 + j);
            chk("R9 entry chan", log_chan, 0);
            pop();
        end
        chk("R9 empty after", log_empty, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule